// File: doc/BRIEF.md
# SDRAM Bank Open-Row Tracker

This block keeps a shadow copy of which row, if any, is open in each bank of a multi-bank synchronous DRAM. It watches the decoded command stream that a controller sends to the memory. It updates its per-bank state on activates, reads and writes that carry the auto-close flag, and single-bank or all-bank precharges. A controller's scheduler uses the tracker to decide what a new access needs. It presents a request (bank, row) and gets back one of three answers in the same cycle: the row is already open (hit), the bank is closed and needs an activate, or a different row is open and must be precharged first.

The tracker also checks the command stream against the bank rules. One cycle after a command that breaks a rule, it raises a one-cycle flag, and that command leaves the stored state untouched. The broken rules are: an activate to a bank that already has an open row, a refresh while any bank is open, and a read or write to a closed bank. Timing counters, command issue and the data path are handled elsewhere. An auto-closing read or write is recorded as closing its bank at the next clock edge.

Top module: `sdram_row_tracker`

## Requirements
- R1: In every cycle outside reset, exactly one of `hit`, `miss_idle` and `miss_conflict` is high. These outputs depend combinationally on `req_bank`, `req_row` and the stored state.
- R2: An activate (`cmd` = 1) to a closed bank records `cmd_row` as the open row of `cmd_bank` from the next clock edge.
- R3: For a request, `hit` means the bank is open on `req_row`. `miss_idle` means the bank is closed. `miss_conflict` means the bank is open on another row.
- R4: A read (`cmd` = 2) or write (`cmd` = 3) with `cmd_a10` = 0 to an open bank leaves that bank open on the same row.
- R5: A read or write with `cmd_a10` = 1 to an open bank closes that bank from the next clock edge. Other banks are not affected.
- R6: A precharge (`cmd` = 4) with `cmd_a10` = 0 closes only `cmd_bank`. With `cmd_a10` = 1 it closes every bank.
- R7: An activate to a bank that is already open raises `illegal_cmd` for exactly the following cycle. The stored row is kept.
- R8: A refresh (`cmd` = 5) while any bank is open raises `illegal_cmd` for the following cycle. A refresh with all banks closed does not raise it. Neither case changes the stored state.
- R9: A read or write to a closed bank raises `illegal_cmd` for the following cycle and leaves the bank closed.
- R10: The idle (`cmd` = 0), mode-set (`cmd` = 6) and burst-stop (`cmd` = 7) codes change no bank state and never raise `illegal_cmd`.
- R11: While `rst` is high at a clock edge, all banks become closed and `illegal_cmd` goes low, whatever command is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Decoded command code (0 idle, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 mode set, 7 burst stop) |
| cmd_bank | input | BANK_W (2) | Bank addressed by the command |
| cmd_row | input | ROW_W (13) | Row addressed by an activate |
| cmd_a10 | input | 1 | Auto-close on read/write, all-banks on precharge |
| req_bank | input | BANK_W (2) | Bank of the lookup request |
| req_row | input | ROW_W (13) | Row of the lookup request |
| hit | output | 1 | Requested row is open |
| miss_idle | output | 1 | Requested bank is closed |
| miss_conflict | output | 1 | Requested bank is open on another row |
| illegal_cmd | output | 1 | One-cycle flag for a rule-breaking command seen on the previous edge |

## Verification
The bench builds the tracker with its default four banks and 13-bit rows. Every bank index is therefore reachable. Rows of all zeros and all ones (0x1FFF) are both reachable, so the full-width row compare and the extreme bank addresses are exercised. A stimulus table opens, hits, conflicts and closes rows across several banks. Directed steps then cover reset from an open state and reset presented together with a rule-breaking command.

// File: rtl/sdt_pkg.sv
package sdt_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_MRS = 3'd6,
    CMD_BST = 3'd7
  } sdt_cmd_e;
endpackage

// File: rtl/sdt_cmd_decode.sv
module sdt_cmd_decode
  import sdt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input  sdt_cmd_e              cmd_e,
  input  logic [BANK_W-1:0]     cmd_bank,
  input  logic                  cmd_a10,
  input  logic [NUM_BANKS-1:0]  bank_open,
  output logic [NUM_BANKS-1:0]  open_stb,
  output logic [NUM_BANKS-1:0]  close_stb,
  output logic                  illegal
);
  logic is_rw;
  logic sel_open;

  assign is_rw    = (cmd_e == CMD_RD) || (cmd_e == CMD_WR);
  assign sel_open = bank_open[cmd_bank];

  // Per-bank open/close strobes; only legal commands change state (R2, R5, R6)
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (cmd_bank == BANK_W'(b));
    assign open_stb[b]  = (cmd_e == CMD_ACT) && sel && !bank_open[b];
    assign close_stb[b] = ((cmd_e == CMD_PRE) && (cmd_a10 || sel)) ||
                          (is_rw && cmd_a10 && sel && bank_open[b]);
  end

  // Rule checks (R7, R8, R9)
  always_comb begin
    illegal = 1'b0;
    if ((cmd_e == CMD_ACT) && sel_open)      illegal = 1'b1;
    if ((cmd_e == CMD_REF) && (|bank_open))  illegal = 1'b1;
    if (is_rw && !sel_open)                  illegal = 1'b1;
  end
endmodule

// File: rtl/sdt_bank_slot.sv
module sdt_bank_slot #(
  parameter int ROW_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_stb,
  input  logic             close_stb,
  input  logic [ROW_W-1:0] row_in,
  output logic             valid_q,
  output logic [ROW_W-1:0] row_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
    end else if (open_stb) begin
      valid_q <= 1'b1;
    end else if (close_stb) begin
      valid_q <= 1'b0;
    end
  end

  // Row field carries no reset: it is only read while valid_q is high
  always_ff @(posedge clk) begin
    if (open_stb) row_q <= row_in;
  end
endmodule

// File: rtl/sdt_row_lookup.sv
module sdt_row_lookup #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = $clog2(NUM_BANKS),
  parameter int ROW_W     = 13
) (
  input  logic [NUM_BANKS-1:0]            bank_open,
  input  logic [NUM_BANKS-1:0][ROW_W-1:0] bank_row,
  input  logic [BANK_W-1:0]               req_bank,
  input  logic [ROW_W-1:0]                req_row,
  output logic                            hit,
  output logic                            miss_idle,
  output logic                            miss_conflict
);
  logic             sel_valid;
  logic [ROW_W-1:0] sel_row;
  logic             same_row;

  assign sel_valid = bank_open[req_bank];
  assign sel_row   = bank_row[req_bank];
  assign same_row  = (sel_row == req_row);

  assign hit           = sel_valid && same_row;
  assign miss_idle     = !sel_valid;
  assign miss_conflict = sel_valid && !same_row;
endmodule

// File: rtl/sdram_row_tracker.sv
module sdram_row_tracker
  import sdt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cmd,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [ROW_W-1:0]  cmd_row,
  input  logic              cmd_a10,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  output logic              hit,
  output logic              miss_idle,
  output logic              miss_conflict,
  output logic              illegal_cmd
);
  sdt_cmd_e                        cmd_e;
  logic [NUM_BANKS-1:0]            bank_open;
  logic [NUM_BANKS-1:0][ROW_W-1:0] bank_row;
  logic [NUM_BANKS-1:0]            open_stb;
  logic [NUM_BANKS-1:0]            close_stb;
  logic                            illegal_c;

  assign cmd_e = sdt_cmd_e'(cmd);

  sdt_cmd_decode #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_decode (
    .cmd_e     (cmd_e),
    .cmd_bank  (cmd_bank),
    .cmd_a10   (cmd_a10),
    .bank_open (bank_open),
    .open_stb  (open_stb),
    .close_stb (close_stb),
    .illegal   (illegal_c)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_slot
    sdt_bank_slot #(.ROW_W(ROW_W)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .open_stb  (open_stb[b]),
      .close_stb (close_stb[b]),
      .row_in    (cmd_row),
      .valid_q   (bank_open[b]),
      .row_q     (bank_row[b])
    );
  end

  sdt_row_lookup #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_lookup (
    .bank_open     (bank_open),
    .bank_row      (bank_row),
    .req_bank      (req_bank),
    .req_row       (req_row),
    .hit           (hit),
    .miss_idle     (miss_idle),
    .miss_conflict (miss_conflict)
  );

  always_ff @(posedge clk) begin
    if (rst) illegal_cmd <= 1'b0;
    else     illegal_cmd <= illegal_c;
  end
endmodule

// File: rtl/sdram_row_tracker_chk.sv
module sdram_row_tracker_chk
  import sdt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic [2:0]           cmd,
  input logic [BANK_W-1:0]    cmd_bank,
  input logic                 cmd_a10,
  input logic                 hit,
  input logic                 miss_idle,
  input logic                 miss_conflict,
  input logic                 illegal_cmd,
  input logic [NUM_BANKS-1:0] open_q
);
  a_r1_one_outcome: assert property (@(posedge clk) disable iff (rst)
    $countones({hit, miss_idle, miss_conflict}) == 1);

  a_r2_act_opens: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_ACT && !open_q[cmd_bank]) |=> open_q[$past(cmd_bank)]);

  a_r6_pre_all_closes: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PRE && cmd_a10) |=> (open_q == '0));

  a_r7_act_open_flags: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_ACT && open_q[cmd_bank]) |=> illegal_cmd);

  a_r8_ref_flags: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_REF && (|open_q)) |=> illegal_cmd);

  a_r10_nop_stable: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_NOP) |=> ($stable(open_q) && !illegal_cmd));

  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> ((open_q == '0) && !illegal_cmd));
endmodule

bind sdram_row_tracker sdram_row_tracker_chk #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cmd           (cmd),
  .cmd_bank      (cmd_bank),
  .cmd_a10       (cmd_a10),
  .hit           (hit),
  .miss_idle     (miss_idle),
  .miss_conflict (miss_conflict),
  .illegal_cmd   (illegal_cmd),
  .open_q        (bank_open)
);

// File: tb/sdram_row_tracker_bench.sv
`timescale 1ns/1ps
module sdram_row_tracker_bench;
  localparam int NB = 4;
  localparam int RW = 13;
  localparam int BW = 2;
  // outcome codes: 0 hit, 1 idle, 2 conflict
  localparam int NV = 19;
  // {cmd[3], bank[2], row[13], a10, req_bank[2], req_row[13], outcome[2], illegal}
  localparam logic [36:0] VEC [NV] = '{
    {3'd1, 2'd0, 13'h0123, 1'b0, 2'd0, 13'h0123, 2'd0, 1'b0}, // R2 R3 open b0, hit
    {3'd0, 2'd0, 13'h0000, 1'b0, 2'd0, 13'h0124, 2'd2, 1'b0}, // R3 conflict
    {3'd0, 2'd0, 13'h0000, 1'b0, 2'd1, 13'h0123, 2'd1, 1'b0}, // R3 idle other bank
    {3'd1, 2'd0, 13'h0050, 1'b0, 2'd0, 13'h0123, 2'd0, 1'b1}, // R7 act to open bank, row kept
    {3'd2, 2'd0, 13'h0000, 1'b0, 2'd0, 13'h0123, 2'd0, 1'b0}, // R4 read keeps row
    {3'd3, 2'd0, 13'h0000, 1'b1, 2'd0, 13'h0123, 2'd1, 1'b0}, // R5 write auto-close
    {3'd2, 2'd0, 13'h0000, 1'b0, 2'd0, 13'h0000, 2'd1, 1'b1}, // R9 read closed bank
    {3'd1, 2'd1, 13'h1FFF, 1'b0, 2'd1, 13'h1FFF, 2'd0, 1'b0}, // R2 max row
    {3'd1, 2'd3, 13'h0000, 1'b0, 2'd3, 13'h0000, 2'd0, 1'b0}, // R2 last bank, row 0
    {3'd5, 2'd0, 13'h0000, 1'b0, 2'd3, 13'h0000, 2'd0, 1'b1}, // R8 refresh with banks open
    {3'd4, 2'd1, 13'h0000, 1'b0, 2'd1, 13'h1FFF, 2'd1, 1'b0}, // R6 single precharge
    {3'd0, 2'd0, 13'h0000, 1'b0, 2'd3, 13'h0001, 2'd2, 1'b0}, // R6 other bank untouched
    {3'd1, 2'd2, 13'h0AAA, 1'b0, 2'd2, 13'h0AAA, 2'd0, 1'b0}, // R2 open b2
    {3'd4, 2'd0, 13'h0000, 1'b1, 2'd2, 13'h0AAA, 2'd1, 1'b0}, // R6 precharge all
    {3'd0, 2'd0, 13'h0000, 1'b0, 2'd3, 13'h0000, 2'd1, 1'b0}, // R6 b3 closed too
    {3'd5, 2'd0, 13'h0000, 1'b0, 2'd0, 13'h0000, 2'd1, 1'b0}, // R8 legal refresh
    {3'd6, 2'd2, 13'h0AAA, 1'b1, 2'd2, 13'h0AAA, 2'd1, 1'b0}, // R10 mode set no effect
    {3'd1, 2'd2, 13'h0001, 1'b0, 2'd2, 13'h0001, 2'd0, 1'b0}, // R2 reopen after close-all
    {3'd2, 2'd2, 13'h0000, 1'b1, 2'd2, 13'h0001, 2'd1, 1'b0}  // R5 read auto-close
  };

  logic          clk = 1'b0;
  logic          rst;
  logic [2:0]    cmd;
  logic [BW-1:0] cmd_bank;
  logic [RW-1:0] cmd_row;
  logic          cmd_a10;
  logic [BW-1:0] req_bank;
  logic [RW-1:0] req_row;
  logic          hit, miss_idle, miss_conflict, illegal_cmd;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  sdram_row_tracker #(.NUM_BANKS(NB), .ROW_W(RW)) u_sdram_row_tracker (
    .clk(clk), .rst(rst), .cmd(cmd), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .cmd_a10(cmd_a10), .req_bank(req_bank), .req_row(req_row), .hit(hit),
    .miss_idle(miss_idle), .miss_conflict(miss_conflict), .illegal_cmd(illegal_cmd)
  );

  function automatic int outcome();
    if ($countones({hit, miss_idle, miss_conflict}) != 1) return 3;
    if (hit) return 0;
    if (miss_idle) return 1;
    return 2;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] c, input int b, input int r, input logic a,
                      input int qb, input int qr);
    @(negedge clk);
    cmd = c; cmd_bank = BW'(b); cmd_row = RW'(r); cmd_a10 = a;
    req_bank = BW'(qb); req_row = RW'(qr);
    @(posedge clk);
    #1;
  endtask

  initial begin
    rst = 1'b1; cmd = 3'd0; cmd_bank = '0; cmd_row = '0; cmd_a10 = 1'b0;
    req_bank = '0; req_row = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R11 reset state, R1 single outcome
    chk("R11 reset bank0 idle", outcome(), 1);
    chk("R11 reset illegal low", int'(illegal_cmd), 0);

    for (int i = 0; i < NV; i++) begin
      logic [36:0] e;
      e = VEC[i];
      step(e[36:34], int'(e[33:32]), int'(e[31:19]), e[18], int'(e[17:16]), int'(e[15:3]));
      chk($sformatf("R3 outcome vector %0d", i), outcome(), int'(e[2:1]));
      chk($sformatf("R7/R8/R9 illegal vector %0d", i), int'(illegal_cmd), int'(e[0]));
    end

    // R10 burst stop: no effect, b2 stays closed, b1 opened then bst
    step(3'd1, 1, 13'h0042, 1'b0, 1, 13'h0042);
    step(3'd7, 1, 0, 1'b1, 1, 13'h0042);
    chk("R10 burst stop keeps row", outcome(), 0);
    chk("R10 burst stop no flag", int'(illegal_cmd), 0);

    // R11 reset from open state together with a rule-breaking activate
    @(negedge clk);
    rst = 1'b1; cmd = 3'd1; cmd_bank = 2'd1; cmd_row = 13'h0007;
    @(negedge clk);
    rst = 1'b0; cmd = 3'd0;
    req_bank = 2'd1; req_row = 13'h0042;
    #1;
    chk("R11 reset closes open bank", outcome(), 1);
    chk("R11 reset clears flag", int'(illegal_cmd), 0);
    req_row = 13'h0007;
    #1;
    chk("R11 act during reset ignored", outcome(), 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule